// File: doc/BRIEF.md
# Alternate-Space Load/Store Formatter

This stage sits on the load/store path. For each request it takes an 8-bit access-space code, an access size, a sign flag, an address and a data word. It then produces the data and address as the memory side should see them one cycle later. The stage does three things:

- It applies a two-level privilege check. Failing it raises a privileged-action fault.
- It reverses byte order for the spaces that are little-endian.
- It sign-extends narrow loads to the full 64-bit word.

A store also has its address forced to natural alignment, and only a store that does not fault asserts the write enable.

The control core is a four-state result machine. The state register records what was accepted on the previous edge:

- `ST_IDLE`: nothing was accepted.
- `ST_LOAD`: a load without a fault was accepted.
- `ST_STORE`: a store without a fault was accepted.
- `ST_FAULT`: a rejected access was accepted.

On every clock, any state moves as follows:

- to `ST_IDLE` when `req_valid` is low;
- to `ST_FAULT` when the privilege check fails;
- otherwise to `ST_STORE` or `ST_LOAD`, according to `req_store`.

The output process decodes the state into `out_valid`, `out_wr_en` and `out_fault`.

Top module: `asi_fmt_top`

## Requirements
- R1: While `rst_n` is low, and on the first output after its release, `out_valid`, `out_wr_en` and `out_fault` are 0, and `out_data` and `out_addr` are zero.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `req_valid` was 1, and it is 0 after a cycle without a request.
- R3: A request whose space code is below 0x80 while `req_priv` is 0 sets `out_fault` in the following cycle.
- R4: A request whose space code lies in 0x30..0x7F while `req_hpriv` is 0 sets `out_fault` in the following cycle. Codes 0x2F and below, and 0x80 and above, need no hyper-privilege.
- R5: For a faulting request, `out_data` and `out_addr` are zero.
- R6: The size encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Only the low bytes of that size are kept, and the bytes above them are zero unless R10 applies.
- R7: A load in space 0x0C, 0x18, 0x19, 0x1C, 0x1D, 0x88, 0x89, 0x8A or 0x8B reverses the byte order within its 2-, 4- or 8-byte size.
- R8: A 1-byte access is never reordered, in any space.
- R9: A store reverses bytes for the load list of R7 except 0x8A and 0x8B. A store in those two spaces passes its data in its given order.
- R10: A signed 1-, 2- or 4-byte load fills the upper bits with the top bit of the reordered value.
- R11: The sign flag has no effect on 8-byte loads or on any store.
- R12: A store's `out_addr` has bit 0 cleared for 2 bytes, bits 1:0 for 4 bytes and bits 2:0 for 8 bytes, and is unchanged for 1 byte. A load's address passes unchanged.
- R13: `out_wr_en` is 1 only in the cycle after a store that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_space | input | 8 | Access-space code |
| req_size | input | SIZE_W (2) | Size code, see R6 |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_priv | input | 1 | Requester is in privileged state |
| req_hpriv | input | 1 | Requester is in hyper-privileged state |
| req_addr | input | ADDR_W (64) | Access address |
| req_data | input | DATA_W (64) | Load data from memory, or store data from the core |
| out_valid | output | 1 | Result present |
| out_wr_en | output | 1 | Store may be written |
| out_fault | output | 1 | Privileged-action fault |
| out_data | output | DATA_W (64) | Formatted data |
| out_addr | output | ADDR_W (64) | Address, aligned for stores |

## Verification
The checker watches these relations on every cycle, from the ports alone:

- the one-cycle valid latency;
- both privilege-fault conditions;
- the zero data on a fault;
- the write enable being confined to stores that do not fault;
- 8-byte store alignment;
- the pass-through of unsigned single bytes.

The byte-reversal space lists, the store-side exclusion of 0x8A/0x8B, sign extension after reversal, and the privilege boundaries at 0x2F/0x30 and 0x7F/0x80 are value-specific. Only the bench's vector table shows them. The reset state, including a reset that lands while a result is held, is likewise shown only by the bench's directed steps.

// File: rtl/asi_fmt_pkg.sv
package asi_fmt_pkg;

    localparam int unsigned SPACE_W = 8;

    // Codes at or above this need no privilege.
    localparam logic [SPACE_W-1:0] KERNEL_LIMIT = 8'h80;
    // Codes from here up to KERNEL_LIMIT-1 also need hyper-privilege.
    localparam logic [SPACE_W-1:0] HYPER_LOW    = 8'h30;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STORE,
        ST_FAULT
    } fmt_state_e;

    // Spaces whose loads are little-endian.
    function automatic logic le_on_load(input logic [SPACE_W-1:0] sp);
        unique case (sp)
            8'h0C, 8'h18, 8'h19, 8'h1C, 8'h1D,
            8'h88, 8'h89, 8'h8A, 8'h8B: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    // Store list: the two read-only no-fault codes are left out.
    function automatic logic le_on_store(input logic [SPACE_W-1:0] sp);
        unique case (sp)
            8'h0C, 8'h18, 8'h19, 8'h1C, 8'h1D,
            8'h88, 8'h89:               return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/asi_priv_check.sv
module asi_priv_check
    import asi_fmt_pkg::*;
(
    input  logic [SPACE_W-1:0] space,
    input  logic               priv,
    input  logic               hpriv,
    output logic               fault
);

    logic below_kernel;
    logic in_hyper;

    always_comb begin
        below_kernel = (space < KERNEL_LIMIT);
        in_hyper     = below_kernel && (space >= HYPER_LOW);
        fault        = (below_kernel && !priv) || (in_hyper && !hpriv);
    end

endmodule

// File: rtl/asi_lane_swap.sv
module asi_lane_swap #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SIZE_W-1:0] size,
    input  logic              swap_en,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    int nb;

    // Keep the low nb lanes, optionally mirrored; clear the rest.
    always_comb begin
        nb   = 32'(1) << size;
        dout = '0;
        for (int i = 0; i < NB; i++) begin
            if (i < nb) begin
                if (swap_en)
                    dout[8*i +: 8] = din[8*(nb-1-i) +: 8];
                else
                    dout[8*i +: 8] = din[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/asi_sign_ext.sv
module asi_sign_ext #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SIZE_W-1:0] size,
    input  logic              ext_en,
    output logic [DATA_W-1:0] dout
);

    localparam int NB = DATA_W / 8;

    int  nb;
    logic top_bit;

    // Lanes above the access size copy its top bit; full width is untouched.
    always_comb begin
        nb      = 32'(1) << size;
        top_bit = din[8*nb-1];
        dout    = din;
        if (ext_en) begin
            for (int b = 0; b < NB; b++) begin
                if (b >= nb)
                    dout[8*b +: 8] = {8{top_bit}};
            end
        end
    end

endmodule

// File: rtl/asi_addr_align.sv
module asi_addr_align #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] din,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] dout
);

    logic [ADDR_W-1:0] keep_mask;

    always_comb begin
        keep_mask = {ADDR_W{1'b1}} << size;
        dout      = din & keep_mask;
    end

endmodule

// File: rtl/asi_fmt_top.sv
module asi_fmt_top
    import asi_fmt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int SIZE_W = $clog2($clog2(DATA_W / 8) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               req_signed,
    input  logic               req_priv,
    input  logic               req_hpriv,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    output logic               out_valid,
    output logic               out_wr_en,
    output logic               out_fault,
    output logic [DATA_W-1:0]  out_data,
    output logic [ADDR_W-1:0]  out_addr
);

    fmt_state_e        state_q, state_d;
    logic              fault_c;
    logic              swap_c;
    logic              ext_c;
    logic [DATA_W-1:0] swapped_c;
    logic [DATA_W-1:0] shaped_c;
    logic [ADDR_W-1:0] aligned_c;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;

    asi_priv_check u_priv (
        .space (req_space),
        .priv  (req_priv),
        .hpriv (req_hpriv),
        .fault (fault_c)
    );

    always_comb begin
        swap_c = req_store ? le_on_store(req_space) : le_on_load(req_space);
        ext_c  = !req_store && req_signed;
    end

    asi_lane_swap #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_swap (
        .din     (req_data),
        .size    (req_size),
        .swap_en (swap_c),
        .dout    (swapped_c)
    );

    asi_sign_ext #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_sext (
        .din    (swapped_c),
        .size   (req_size),
        .ext_en (ext_c),
        .dout   (shaped_c)
    );

    asi_addr_align #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_align (
        .din  (req_addr),
        .size (req_size),
        .dout (aligned_c)
    );

    // Next-state decode: the result kind of the request now on the inputs.
    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (fault_c)
            state_d = ST_FAULT;
        else if (req_store)
            state_d = ST_STORE;
        else
            state_d = ST_LOAD;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Data path registers: zero unless an accepted request does not fault.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (req_valid && !fault_c) begin
            data_q <= shaped_c;
            addr_q <= req_store ? aligned_c : req_addr;
        end else begin
            data_q <= '0;
            addr_q <= '0;
        end
    end

    // Output decode from the state.
    always_comb begin
        out_valid = 1'b0;
        out_wr_en = 1'b0;
        out_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOAD:  out_valid = 1'b1;
            ST_STORE: begin
                out_valid = 1'b1;
                out_wr_en = 1'b1;
            end
            ST_FAULT: begin
                out_valid = 1'b1;
                out_fault = 1'b1;
            end
            default:  ;
        endcase
        out_data = data_q;
        out_addr = addr_q;
    end

endmodule

// File: rtl/asi_fmt_chk.sv
module asi_fmt_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [7:0]        req_space,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_signed,
    input logic              req_priv,
    input logic              req_hpriv,
    input logic [DATA_W-1:0] req_data,
    input logic              out_valid,
    input logic              out_wr_en,
    input logic              out_fault,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W-1:0] out_addr
);

    logic kern_miss;
    logic hyp_miss;
    logic any_miss;

    always_comb begin
        kern_miss = req_space[7] == 1'b0 && !req_priv;
        hyp_miss  = req_space[7] == 1'b0 && req_space >= 8'h30 && !req_hpriv;
        any_miss  = kern_miss || hyp_miss;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_kernel_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kern_miss) |=> out_fault);

    assert_hyper_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hyp_miss) |=> out_fault);

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_data == '0 && out_addr == '0));

    assert_no_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_miss) |=> !out_fault);

    assert_byte_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_miss && !req_store && !req_signed && req_size == '0)
        |=> out_data == {{(DATA_W-8){1'b0}}, $past(req_data[7:0])});

    assert_wide_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_miss && req_store && req_size == 2'd3)
        |=> out_addr[2:0] == 3'b000);

    assert_wren_store_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !any_miss) |=> out_wr_en);

    assert_wren_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_valid && !out_fault));

    assert_wren_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> !out_wr_en);

endmodule

bind asi_fmt_top asi_fmt_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_space  (req_space),
    .req_size   (req_size),
    .req_signed (req_signed),
    .req_priv   (req_priv),
    .req_hpriv  (req_hpriv),
    .req_data   (req_data),
    .out_valid  (out_valid),
    .out_wr_en  (out_wr_en),
    .out_fault  (out_fault),
    .out_data   (out_data),
    .out_addr   (out_addr)
);

// File: tb/asi_fmt_top_tb_top.sv
`timescale 1ns/1ps
module asi_fmt_top_tb_top;

    localparam logic [63:0] AV = 64'h0000_0000_1000_0007;
    localparam logic [63:0] DV = 64'h0123_4567_89AB_CDEF;
    localparam int NV = 23;

    typedef struct packed {
        logic [23:0] tag;
        logic        st;
        logic [7:0]  sp;
        logic [1:0]  sz;
        logic        sg;
        logic        pr;
        logic        hp;
        logic [63:0] e_data;
        logic [63:0] e_addr;
        logic        e_wr;
        logic        e_flt;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{"R7 ", 1'b0, 8'h88, 2'd3, 1'b0, 1'b1, 1'b1, 64'hEFCD_AB89_6745_2301, AV, 1'b0, 1'b0},
        '{"R7 ", 1'b0, 8'h0C, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_EFCD_AB89, AV, 1'b0, 1'b0},
        '{"R7 ", 1'b0, 8'h19, 2'd1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_EFCD, AV, 1'b0, 1'b0},
        '{"R6 ", 1'b0, 8'h80, 2'd1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_CDEF, AV, 1'b0, 1'b0},
        '{"R10", 1'b0, 8'h80, 2'd1, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_CDEF, AV, 1'b0, 1'b0},
        '{"R10", 1'b0, 8'h8A, 2'd2, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_EFCD_AB89, AV, 1'b0, 1'b0},
        '{"R8 ", 1'b0, 8'h88, 2'd0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_00EF, AV, 1'b0, 1'b0},
        '{"R10", 1'b0, 8'h88, 2'd0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFEF, AV, 1'b0, 1'b0},
        '{"R11", 1'b0, 8'h80, 2'd3, 1'b1, 1'b1, 1'b1, DV, AV, 1'b0, 1'b0},
        '{"R9 ", 1'b1, 8'h8A, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_89AB_CDEF, 64'h1000_0004, 1'b1, 1'b0},
        '{"R9 ", 1'b1, 8'h89, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_EFCD_AB89, 64'h1000_0004, 1'b1, 1'b0},
        '{"R12", 1'b1, 8'h80, 2'd3, 1'b0, 1'b1, 1'b1, DV, 64'h1000_0000, 1'b1, 1'b0},
        '{"R12", 1'b1, 8'h80, 2'd1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_CDEF, 64'h1000_0006, 1'b1, 1'b0},
        '{"R12", 1'b1, 8'h80, 2'd0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_00EF, AV, 1'b1, 1'b0},
        '{"R11", 1'b1, 8'h80, 2'd1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_CDEF, 64'h1000_0006, 1'b1, 1'b0},
        '{"R3 ", 1'b0, 8'h10, 2'd3, 1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 1'b0, 1'b1},
        '{"R4 ", 1'b0, 8'h45, 2'd3, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1},
        '{"R13", 1'b1, 8'h50, 2'd3, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1},
        '{"R4 ", 1'b0, 8'h2F, 2'd3, 1'b0, 1'b1, 1'b0, DV, AV, 1'b0, 1'b0},
        '{"R3 ", 1'b0, 8'h80, 2'd3, 1'b0, 1'b0, 1'b0, DV, AV, 1'b0, 1'b0},
        '{"R4 ", 1'b0, 8'h30, 2'd3, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1},
        '{"R4 ", 1'b0, 8'h7F, 2'd3, 1'b0, 1'b1, 1'b1, DV, AV, 1'b0, 1'b0},
        '{"R5 ", 1'b1, 8'h1C, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [7:0]  req_space = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic        req_priv = 1'b0;
    logic        req_hpriv = 1'b0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic        out_valid, out_wr_en, out_fault;
    logic [63:0] out_data, out_addr;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    asi_fmt_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_store  (req_store),
        .req_space  (req_space),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_priv   (req_priv),
        .req_hpriv  (req_hpriv),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .out_valid  (out_valid),
        .out_wr_en  (out_wr_en),
        .out_fault  (out_fault),
        .out_data   (out_data),
        .out_addr   (out_addr)
    );

    task automatic check_out(input string tag, input logic v, input logic w, input logic f,
                             input logic [63:0] d, input logic [63:0] a);
        total++;
        if (out_valid !== v || out_wr_en !== w || out_fault !== f ||
            out_data !== d || out_addr !== a) begin
            bad++;
            $display("FAIL %s: got v=%b w=%b f=%b d=%h a=%h, want v=%b w=%b f=%b d=%h a=%h",
                     tag, out_valid, out_wr_en, out_fault, out_data, out_addr,
                     v, w, f, d, a);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hang, want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs held at zero during reset
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);

        // Vector table: drive at a falling edge, sample at the next one.
        req_addr = AV;
        req_data = DV;
        for (int k = 0; k < NV; k++) begin
            req_valid  = 1'b1;
            req_store  = VECS[k].st;
            req_space  = VECS[k].sp;
            req_size   = VECS[k].sz;
            req_signed = VECS[k].sg;
            req_priv   = VECS[k].pr;
            req_hpriv  = VECS[k].hp;
            @(negedge clk);
            check_out(string'(VECS[k].tag), 1'b1, VECS[k].e_wr, VECS[k].e_flt,
                      VECS[k].e_data, VECS[k].e_addr);
        end

        // R2: no request means no result.
        req_valid = 1'b0;
        @(negedge clk);
        check_out("R2", 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);

        // R13: a load after a store drops the write enable; R2 resumes valid.
        req_valid = 1'b1; req_store = 1'b0; req_space = 8'h80; req_size = 2'd2;
        req_signed = 1'b0; req_priv = 1'b1; req_hpriv = 1'b1;
        @(negedge clk);
        check_out("R13", 1'b1, 1'b0, 1'b0, 64'h0000_0000_89AB_CDEF, AV);

        // R1: reset while a store result is held clears everything.
        req_store = 1'b1; req_size = 2'd3;
        @(negedge clk);
        check_out("R12", 1'b1, 1'b1, 1'b0, DV, 64'h1000_0000);
        req_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check_out("R1", 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0, 64'h0, 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule